// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a 20-bit physical frame number and a set of access permissions. It does this for one of 128 address-space identifiers by reading a two-level translation structure held in external memory. An upstream translation cache calls it after a miss. Every address space has a root word that names the physical frame of its directory. The root words live inside the block. Software loads them in two steps: it first writes the identifier to a select register, then writes the root word to a data register, which stores it in the slot chosen by the select.

On an accepted request the walker reads one directory entry. It reads a table entry only when the directory entry is marked as pointing to a next-level table. The walker then returns the frame number, the permissions that all three levels share, or a fault. When the global enable is clear, the walker hands the address straight back untranslated and makes no memory access. Only one walk is in progress at any time. The request side stays busy until the response has been produced.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0, and translation is disabled.
- R2: Register index 0, bit 0, is the global enable. Its value is sampled when a request is accepted. While it is 0, the response comes one cycle after acceptance with rsp_frame_o equal to virtual address bits 31:12, rsp_perm_o equal to 3'b111 and rsp_fault_o equal to 0, and no memory read takes place.
- R3: A write to register index 1 selects the identifier from bits 6:0. A write to register index 2 stores the word into the root slot of the selected identifier only, and leaves every other slot unchanged. A root slot that holds zero, including one never written since reset, makes a request fault one cycle after acceptance with no memory read.
- R4: The directory entry is read from address {root bits 19:0, virtual address bits 31:22, 2'b00}.
- R5: A directory entry that equals zero, or that has bit 28 (next-level) clear, ends the walk with a fault after exactly one memory read.
- R6: The table entry is read from address {directory entry bits 19:0, virtual address bits 21:12, 2'b00}.
- R7: A table entry that equals zero ends the walk with a fault after two memory reads.
- R8: A successful walk returns rsp_frame_o equal to table entry bits 19:0. rsp_perm_o is the bitwise AND of bits 31:29 of the root, the directory entry and the table entry, where bit 2 is read, bit 1 is write and bit 0 is nonsecure.
- R9: From acceptance until the response, req_ready_o is 0 whenever a memory read is in progress. rsp_valid_o is a single-cycle pulse, raised in the cycle after the final mem_rvalid_i or after acceptance, and req_ready_o is 1 while it is high.
- R10: mem_req_o stays high with mem_addr_o unchanged until mem_rvalid_i is seen.
- R11: A faulting response carries rsp_frame_o equal to 0 and rsp_perm_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index: 0 enable, 1 identifier select, 2 root data |
| reg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_asid_i | input | 7 | Address-space identifier |
| req_va_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_frame_o | output | 20 | Physical frame number |
| rsp_perm_o | output | 3 | Permissions {read, write, nonsecure} |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The checks assume that memory raises mem_rvalid_i only while mem_req_o is high, for one cycle per read. They also assume that the enable does not change between the acceptance of a request and the sampling of its pass-through response. The bench memory model starts a read only when it sees mem_req_o with no read pending. It answers after a fixed per-test latency of one to three cycles, then drops rvalid at the next falling edge. All register writes are issued while the walker is idle.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int WORD_W   = 32;
  localparam int ATTR_RD  = 31;
  localparam int ATTR_WR  = 30;
  localparam int ATTR_NS  = 29;
  localparam int BIT_NEXT = 28;
  localparam int FRM_W    = 20;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_ROOT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_TBL} walk_st_e;

  typedef struct packed {
    logic             valid;
    logic             next;
    logic [2:0]       perm;
    logic [FRM_W-1:0] frame;
  } entry_t;
endpackage

// File: rtl/entry_decode.sv
module entry_decode
  import walk_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output entry_t            ent_o
);
  always_comb begin
    ent_o.valid = |word_i;
    ent_o.next  = word_i[BIT_NEXT];
    ent_o.perm  = {word_i[ATTR_RD], word_i[ATTR_WR], word_i[ATTR_NS]};
    ent_o.frame = word_i[FRM_W-1:0];
  end
endmodule

// File: rtl/root_table.sv
module root_table
  import walk_pkg::*;
#(
  parameter int ASID_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ASID_W-1:0] rd_asid_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int NUM_AS = 1 << ASID_W;

  logic [ASID_W-1:0] sel_q;
  logic [WORD_W-1:0] slot_q [NUM_AS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= wdata_i[ASID_W-1:0];
  end

  for (genvar g = 0; g < NUM_AS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (data_we_i && sel_q == ASID_W'(g))      slot_q[g] <= wdata_i;
    end
  end

  assign rd_word_o = slot_q[rd_asid_i];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int IDX_W  = 10,
  parameter int ASID_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [FRM_W-1:0]  rsp_frame_o,
  output logic [2:0]        rsp_perm_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int PG_SH = VA_W - 2 * IDX_W;

  walk_st_e          st_q;
  logic              en_q;
  logic [IDX_W-1:0]  tidx_q;
  logic [2:0]        perm_q;
  logic [WORD_W-1:0] addr_q;
  logic              rsp_v_q, rsp_f_q;
  logic [FRM_W-1:0]  rsp_frm_q;
  logic [2:0]        rsp_perm_q;
  logic [WORD_W-1:0] root_word;
  entry_t            root_ent, mem_ent;
  logic              accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                en_q <= 1'b0;
    else if (reg_wr_i && reg_idx_i == REG_CTRL) en_q <= reg_wdata_i[0];
  end

  root_table #(.ASID_W(ASID_W)) u_root (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_we_i  (reg_wr_i && reg_idx_i == REG_SEL),
    .data_we_i (reg_wr_i && reg_idx_i == REG_ROOT),
    .wdata_i   (reg_wdata_i),
    .rd_asid_i (req_asid_i),
    .rd_word_o (root_word)
  );

  entry_decode u_dec_root (.word_i(root_word),   .ent_o(root_ent));
  entry_decode u_dec_mem  (.word_i(mem_rdata_i), .ent_o(mem_ent));

  assign accept = req_valid_i && st_q == ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tidx_q     <= '0;
      perm_q     <= '0;
      addr_q     <= '0;
      rsp_v_q    <= 1'b0;
      rsp_f_q    <= 1'b0;
      rsp_frm_q  <= '0;
      rsp_perm_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (!en_q) begin
            rsp_v_q    <= 1'b1;
            rsp_f_q    <= 1'b0;
            rsp_frm_q  <= req_va_i[VA_W-1:PG_SH];
            rsp_perm_q <= 3'b111;
          end else if (!root_ent.valid) begin
            rsp_v_q    <= 1'b1;
            rsp_f_q    <= 1'b1;
            rsp_frm_q  <= '0;
            rsp_perm_q <= '0;
          end else begin
            st_q   <= ST_DIR;
            addr_q <= {root_ent.frame, req_va_i[VA_W-1:VA_W-IDX_W], 2'b00};
            tidx_q <= req_va_i[PG_SH+IDX_W-1:PG_SH];
            perm_q <= root_ent.perm;
          end
        end
        ST_DIR: if (mem_rvalid_i) begin
          // sections are not supported: a leaf directory entry faults
          if (!mem_ent.valid || !mem_ent.next) begin
            st_q       <= ST_IDLE;
            rsp_v_q    <= 1'b1;
            rsp_f_q    <= 1'b1;
            rsp_frm_q  <= '0;
            rsp_perm_q <= '0;
          end else begin
            st_q   <= ST_TBL;
            addr_q <= {mem_ent.frame, tidx_q, 2'b00};
            perm_q <= perm_q & mem_ent.perm;
          end
        end
        ST_TBL: if (mem_rvalid_i) begin
          st_q    <= ST_IDLE;
          rsp_v_q <= 1'b1;
          if (!mem_ent.valid) begin
            rsp_f_q    <= 1'b1;
            rsp_frm_q  <= '0;
            rsp_perm_q <= '0;
          end else begin
            rsp_f_q    <= 1'b0;
            rsp_frm_q  <= mem_ent.frame;
            rsp_perm_q <= perm_q & mem_ent.perm;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = st_q == ST_IDLE;
  assign mem_req_o   = st_q != ST_IDLE;
  assign mem_addr_o  = addr_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_fault_o = rsp_f_q;
  assign rsp_frame_o = rsp_frm_q;
  assign rsp_perm_o  = rsp_perm_q;
endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
  parameter int VA_W  = 32,
  parameter int PG_SH = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_q,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [19:0]     rsp_frame_o,
  input logic [2:0]      rsp_perm_o,
  input logic            mem_req_o,
  input logic [31:0]     mem_addr_o,
  input logic            mem_rvalid_i
);
  // input assumption: read data only answers an open request
  a_r10_rvalid_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> mem_req_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r9_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  a_r9_rsp_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_rvalid_i) || $past(req_valid_i && req_ready_o));

  a_r11_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_frame_o == '0 && rsp_perm_o == '0);

  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !en_q |=> rsp_valid_o && !rsp_fault_o &&
      !mem_req_o && rsp_perm_o == 3'b111 &&
      rsp_frame_o == $past(req_va_i[VA_W-1:PG_SH]));
endmodule

bind pt_walker walk_chk #(.VA_W(VA_W), .PG_SH(PG_SH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_q         (en_q),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_va_i     (req_va_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_frame_o  (rsp_frame_o),
  .rsp_perm_o   (rsp_perm_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [6:0]  req_asid_i = '0;
  logic [31:0] req_va_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [19:0] rsp_frame_o;
  logic [2:0]  rsp_perm_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  pt_walker u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // memory model
  logic [31:0] mem_m [logic [31:0]];
  int          lat = 1, wait_c = 0, rd_cnt = 0;
  bit          pend = 0;
  logic [31:0] pend_addr, addr_log [4];

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  always @(negedge clk_i) begin
    if (mem_rvalid_i) begin
      mem_rvalid_i = 1'b0;
      pend = 0;
    end else if (pend) begin
      if (wait_c == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd_mem(pend_addr);
      end else wait_c--;
    end else if (mem_req_o) begin
      pend = 1;
      pend_addr = mem_addr_o;
      wait_c = lat - 1;
      if (rd_cnt < 4) addr_log[rd_cnt] = mem_addr_o;
      rd_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  logic        g_fault, g_ready;
  logic [19:0] g_frame;
  logic [2:0]  g_perm;
  int          g_lat;

  task automatic run_req(input logic [6:0] asid, input logic [31:0] va);
    @(negedge clk_i);
    rd_cnt = 0;
    req_valid_i = 1'b1; req_asid_i = asid; req_va_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    g_ready = req_ready_o;
    g_lat = 1;
    while (!rsp_valid_o && g_lat < 100) begin
      @(negedge clk_i);
      g_lat++;
    end
    g_fault = rsp_fault_o; g_frame = rsp_frame_o; g_perm = rsp_perm_o;
    @(negedge clk_i);
    chk("R9 pulse", rsp_valid_o, 1'b0);
  endtask

  typedef struct packed {
    logic [6:0]  asid;
    logic [31:0] root;
    logic [31:0] va;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [1:0]  lat;
    logic        fault;
    logic [19:0] frame;
    logic [2:0]  perm;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{7'd5, 32'hE000_0123, 32'h0040_3000, 32'hF000_0200, 32'hE00A_BCDE, 2'd1, 1'b0, 20'hABCDE, 3'b111, 2'd2},
    '{7'd5, 32'hE000_0123, 32'h8020_1000, 32'hB000_0300, 32'hE001_1111, 2'd2, 1'b0, 20'h11111, 3'b101, 2'd2},
    '{7'd5, 32'hE000_0123, 32'h00C0_0000, 32'h0000_0000, 32'h0000_0000, 2'd3, 1'b1, 20'h00000, 3'b000, 2'd1},
    '{7'd5, 32'hE000_0123, 32'h0100_5000, 32'hE000_0400, 32'hE000_0999, 2'd1, 1'b1, 20'h00000, 3'b000, 2'd1},
    '{7'd5, 32'hE000_0123, 32'h0140_6000, 32'hF000_0500, 32'h0000_0000, 2'd2, 1'b1, 20'h00000, 3'b000, 2'd2},
    '{7'd9, 32'h8000_0456, 32'hFFC0_F000, 32'hF000_0600, 32'h6000_0777, 2'd3, 1'b0, 20'h00777, 3'b000, 2'd2}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ready", req_ready_o, 1'b1);
    chk("R1 rsp_valid", rsp_valid_o, 1'b0);
    chk("R1 mem_req", mem_req_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 disabled: pass-through, no read
    run_req(7'd5, 32'h1234_5678);
    chk("R2 frame", g_frame, 20'h12345);
    chk("R2 perm", g_perm, 3'b111);
    chk("R2 fault", g_fault, 1'b0);
    chk("R2 latency", g_lat, 1);
    chk("R2 reads", rd_cnt, 0);

    reg_write(2'd0, 32'h1);

    // table-driven walks (R3..R8, R11)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] pde_a, pte_a;
      v = VECS[i];
      lat = int'(v.lat);
      pde_a = {v.root[19:0], v.va[31:22], 2'b00};
      pte_a = {v.pde[19:0], v.va[21:12], 2'b00};
      mem_m[pde_a] = v.pde;
      if (v.pde[28]) mem_m[pte_a] = v.pte;
      reg_write(2'd1, {25'h0, v.asid});
      reg_write(2'd2, v.root);
      run_req(v.asid, v.va);
      chk($sformatf("R8 frame v%0d", i), g_frame, v.frame);
      chk($sformatf("R8 perm v%0d", i), g_perm, v.perm);
      chk($sformatf("R5 R7 fault v%0d", i), g_fault, v.fault);
      chk($sformatf("R5 R7 reads v%0d", i), rd_cnt, v.reads);
      chk($sformatf("R9 busy v%0d", i), g_ready, 1'b0);
      chk($sformatf("R4 dir addr v%0d", i), addr_log[0], pde_a);
      if (v.reads == 2'd2) chk($sformatf("R6 tbl addr v%0d", i), addr_log[1], pte_a);
    end

    // R3: unwritten root slot faults immediately
    run_req(7'd3, 32'h0040_3000);
    chk("R3 empty fault", g_fault, 1'b1);
    chk("R3 empty reads", rd_cnt, 0);
    chk("R3 empty latency", g_lat, 1);
    chk("R11 frame", g_frame, 20'h0);

    // R3: slot 5 untouched by the write to slot 9
    lat = 1;
    run_req(7'd5, 32'h0040_3000);
    chk("R3 slot kept frame", g_frame, 20'hABCDE);
    chk("R3 slot kept perm", g_perm, 3'b111);

    // R2: enable cleared again restores pass-through
    reg_write(2'd0, 32'h0);
    run_req(7'd5, 32'hFFFF_F123);
    chk("R2 again frame", g_frame, 20'hFFFFF);
    chk("R2 again reads", rd_cnt, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule